// File: doc/BRIEF.md
# Multiprocessor Coherency Register Block

This block is the configuration and status register file of a coherency controller that serves up to four processor cores. It sits on a 32-bit register bus inside a 256-byte window. Each access carries the index of the core that issued it. The block holds a global enable bit. It reports how many cores are present and which of them take part in symmetric multiprocessing (SMP). It also shows four address-filter window registers, which are captured from strap inputs.

Each present core has a lock bit, and once a lock is set it stays set. A core locks itself, or locks another core, by writing 0 to that core's bit in the access register. After that, every write from a locked core is discarded, at every offset. Reads are never gated by the locks.

The filter straps are captured on the first start pulse only. A soft reset clears the locks and the enable bit. It keeps the captured filter values, and it also keeps the record that a capture has already happened. Offsets that are not mapped read as zero, and writes to them are ignored.

Top module: `cohreg_block`

## Requirements
- R1: After the asynchronous reset, the control register reads 0, all four filter registers read 0, and the access register (0x50) reads 1 in the bit of every present core.
- R2: Control register, offset 0x00. Bit 0 is a read/write enable. Bit 1 is a read-only copy of the captured filtering-enable strap. Every other bit reads 0, whatever value was written.
- R3: Configuration register, offset 0x04. Bits [1:0] hold the number of present cores minus one. Bits [7:4] hold a contiguous mask of the present cores, ANDed with the SMP_MASK parameter. All other bits except bit 31 read 0.
- R4: Configuration bit 31 reads 1 only when both the captured master-filter start value and the captured master-filter end value are nonzero.
- R5: Access register, offset 0x50. Bit i belongs to core i. Writing 0 to the bit of a present core locks that core. Writing 1 never unlocks a core. A read returns 1 for each present core that is unlocked, and 0 for cores that are not present.
- R6: A write from a present core whose lock is set changes no register. A write whose core index is at or above the present core count is never gated.
- R7: The filter registers are read-only: master start at 0x40, master end at 0x44, peripheral start at 0x48, peripheral end at 0x4C. Their low 20 bits always read 0.
- R8: The filter values and the filtering-enable flag are captured from the straps on the first start pulse after reset. Later start pulses do not capture them again.
- R9: A soft reset clears all locks and the control enable bit. It keeps the captured filter values and the filtering-enable flag, and a start pulse after it does not capture the straps again.
- R10: The register at 0x54 always reads 0x00000FFF. Writes to it have no effect. Unmapped offsets read 0, and writes to them are ignored.
- R11: A NUM_CORES parameter above four is capped at four present cores.
- R12: Read data and rvalid appear one cycle after rd_en. A read returns data even when the requesting core is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset: clears locks and enable |
| start | input | 1 | Start pulse; the first one captures the straps |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset within the window |
| wdata | input | 32 | Write data |
| core_idx | input | 2 | Index of the requesting core |
| rdata | output | 32 | Read data, valid when rvalid is high |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| strap_filt_en | input | 1 | Filtering-enable strap |
| strap_mst_start | input | 32 | Master filter start strap |
| strap_mst_end | input | 32 | Master filter end strap |
| strap_per_start | input | 32 | Peripheral filter start strap |
| strap_per_end | input | 32 | Peripheral filter end strap |

## Verification
The bench changes the straps and pulses start a second time, both before and after a soft reset. A design that captures again would show the new filter values. Core 1 is locked, and then:
- Core 1 tries to change the enable bit and to clear other locks. A design without gating would apply those writes.
- A write of 1 to core 1's lock bit is issued. A design that lets a 1 clear a lock would unlock core 1.
- A core index above the present count writes to the block. A design that gates by a stale or out-of-range lock bit would drop that write.

Filter values with nonzero low bits expose a missing 20-bit mask. A second instance built with six cores exposes a core count that is not capped.

// File: rtl/cohreg_pkg.sv
package cohreg_pkg;
  localparam int MAX_CORES  = 4;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int CORE_IDX_W = 2;
  localparam int WORD_W     = ADDR_W - 2;

  // word indices (byte offset / 4)
  localparam logic [WORD_W-1:0] W_CTRL = 6'h00;
  localparam logic [WORD_W-1:0] W_CFG  = 6'h01;
  localparam logic [WORD_W-1:0] W_MFS  = 6'h10;
  localparam logic [WORD_W-1:0] W_MFE  = 6'h11;
  localparam logic [WORD_W-1:0] W_PFS  = 6'h12;
  localparam logic [WORD_W-1:0] W_PFE  = 6'h13;
  localparam logic [WORD_W-1:0] W_ACC  = 6'h14;
  localparam logic [WORD_W-1:0] W_NSAC = 6'h15;

  localparam logic [DATA_W-1:0] FILT_KEEP  = 32'hFFF0_0000;
  localparam logic [DATA_W-1:0] NSAC_VALUE = 32'h0000_0FFF;

  typedef struct packed {
    logic              filt_en;
    logic [DATA_W-1:0] mst_start;
    logic [DATA_W-1:0] mst_end;
    logic [DATA_W-1:0] per_start;
    logic [DATA_W-1:0] per_end;
  } strap_set_t;
endpackage

// File: rtl/cohreg_strap_latch.sv
module cohreg_strap_latch
  import cohreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  strap_set_t straps,
  output strap_set_t filt,
  output logic       loaded
);
  strap_set_t filt_q, filt_nxt;
  logic       loaded_q, loaded_nxt;
  logic       capture;

  assign capture = start && !loaded_q;

  always_comb begin
    filt_nxt   = filt_q;
    loaded_nxt = loaded_q;
    if (capture) begin
      filt_nxt   = straps;
      loaded_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q   <= '0;
      loaded_q <= 1'b0;
    end else if (capture) begin
      filt_q   <= filt_nxt;
      loaded_q <= loaded_nxt;
    end
  end

  assign filt   = filt_q;
  assign loaded = loaded_q;

  AST_FILT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> $stable(filt)); // R8
  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded); // R9
endmodule

// File: rtl/cohreg_lock_ctrl.sv
module cohreg_lock_ctrl
  import cohreg_pkg::*;
#(
  parameter int PRESENT = MAX_CORES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 acc_wr,
  input  logic [MAX_CORES-1:0] acc_wdata,
  output logic [MAX_CORES-1:0] lock
);
  localparam logic [MAX_CORES-1:0] PRESENT_MASK = MAX_CORES'((1 << PRESENT) - 1);

  logic [MAX_CORES-1:0] lock_q, lock_nxt;
  logic                 lock_ce;

  assign lock_ce = soft_rst || acc_wr;

  always_comb begin
    lock_nxt = lock_q;
    if (soft_rst)
      lock_nxt = '0;
    else if (acc_wr)
      lock_nxt = lock_q | (~acc_wdata & PRESENT_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_q <= '0;
    else if (lock_ce)
      lock_q <= lock_nxt;
  end

  assign lock = lock_q;

  for (genvar i = 0; i < MAX_CORES; i++) begin : g_lock_chk
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] && !soft_rst |=> lock_q[i]); // R5
  end
  AST_ABSENT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> ((lock_q & ~PRESENT_MASK) == '0)); // R5
endmodule

// File: rtl/cohreg_read_mux.sv
module cohreg_read_mux
  import cohreg_pkg::*;
#(
  parameter int                   PRESENT  = MAX_CORES,
  parameter logic [MAX_CORES-1:0] SMP_MASK = '1
) (
  input  logic [WORD_W-1:0]    word,
  input  logic                 ctrl_en,
  input  strap_set_t           filt,
  input  logic [MAX_CORES-1:0] lock,
  output logic [DATA_W-1:0]    rd_word
);
  localparam logic [MAX_CORES-1:0] PRESENT_MASK = MAX_CORES'((1 << PRESENT) - 1);
  localparam logic [1:0]           CNT_M1       = 2'(PRESENT - 1);
  localparam logic [MAX_CORES-1:0] SMP_SHOWN    = PRESENT_MASK & SMP_MASK;

  logic mport_on;
  assign mport_on = (filt.mst_start != '0) && (filt.mst_end != '0);

  always_comb begin
    rd_word = '0;
    unique case (word)
      W_CTRL:  rd_word = {30'b0, filt.filt_en, ctrl_en};
      W_CFG:   rd_word = {mport_on, 23'b0, SMP_SHOWN, 2'b00, CNT_M1};
      W_MFS:   rd_word = filt.mst_start & FILT_KEEP;
      W_MFE:   rd_word = filt.mst_end   & FILT_KEEP;
      W_PFS:   rd_word = filt.per_start & FILT_KEEP;
      W_PFE:   rd_word = filt.per_end   & FILT_KEEP;
      W_ACC:   rd_word = {28'b0, ~lock & PRESENT_MASK};
      W_NSAC:  rd_word = NSAC_VALUE;
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/cohreg_block.sv
module cohreg_block
  import cohreg_pkg::*;
#(
  parameter int                   NUM_CORES = 4,
  parameter logic [MAX_CORES-1:0] SMP_MASK  = 4'hF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  start,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [CORE_IDX_W-1:0] core_idx,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rvalid,
  input  logic                  strap_filt_en,
  input  logic [DATA_W-1:0]     strap_mst_start,
  input  logic [DATA_W-1:0]     strap_mst_end,
  input  logic [DATA_W-1:0]     strap_per_start,
  input  logic [DATA_W-1:0]     strap_per_end
);
  localparam int PRESENT = (NUM_CORES > MAX_CORES) ? MAX_CORES :
                           (NUM_CORES < 1) ? 1 : NUM_CORES;

  logic [WORD_W-1:0]    word;
  logic                 idx_present;
  logic                 wr_blocked;
  logic                 wr_ok;
  logic [MAX_CORES-1:0] lock;
  strap_set_t           straps, filt;
  logic                 loaded;
  logic [DATA_W-1:0]    rd_word;
  logic                 ctrl_en_q, ctrl_en_nxt, ctrl_ce;
  logic [DATA_W-1:0]    rdata_q;
  logic                 rvalid_q;

  assign word        = addr[ADDR_W-1:2];
  assign idx_present = int'(core_idx) < PRESENT;
  assign wr_blocked  = idx_present && lock[core_idx];
  assign wr_ok       = wr_en && !wr_blocked && !soft_rst;

  assign straps.filt_en   = strap_filt_en;
  assign straps.mst_start = strap_mst_start;
  assign straps.mst_end   = strap_mst_end;
  assign straps.per_start = strap_per_start;
  assign straps.per_end   = strap_per_end;

  cohreg_strap_latch u_straps (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .straps (straps),
    .filt   (filt),
    .loaded (loaded)
  );

  cohreg_lock_ctrl #(.PRESENT(PRESENT)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .acc_wr    (wr_ok && (word == W_ACC)),
    .acc_wdata (wdata[MAX_CORES-1:0]),
    .lock      (lock)
  );

  cohreg_read_mux #(.PRESENT(PRESENT), .SMP_MASK(SMP_MASK)) u_rmux (
    .word    (word),
    .ctrl_en (ctrl_en_q),
    .filt    (filt),
    .lock    (lock),
    .rd_word (rd_word)
  );

  // control enable: next state
  assign ctrl_ce = soft_rst || (wr_ok && (word == W_CTRL));
  always_comb begin
    ctrl_en_nxt = ctrl_en_q;
    if (soft_rst)
      ctrl_en_nxt = 1'b0;
    else if (wr_ok && (word == W_CTRL))
      ctrl_en_nxt = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_en_q <= 1'b0;
    else if (ctrl_ce)
      ctrl_en_q <= ctrl_en_nxt;
  end

  // read return path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en)
        rdata_q <= rd_word;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  AST_LOCKED_NO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_present && lock[core_idx] && !soft_rst |=> $stable(ctrl_en_q)); // R6
  AST_LOCKED_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_present && lock[core_idx] && !soft_rst |=> $stable(lock)); // R6
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (lock == '0) && !ctrl_en_q); // R9
  AST_RVALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R12
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid); // R12
  AST_NSAC_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (word == W_NSAC) |=> (rdata == NSAC_VALUE)); // R10
  AST_FILT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (word[5:2] == 4'h4) |=> (rdata[19:0] == 20'h0)); // R7
endmodule

// File: tb/cohreg_block_test.sv
module cohreg_block_test;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, start, wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [1:0]  core_idx;
  logic [31:0] rdata, rdata_cap;
  logic        rvalid, rvalid_cap;
  logic        s_fen;
  logic [31:0] s_ms, s_me, s_ps, s_pe;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cohreg_block #(.NUM_CORES(3), .SMP_MASK(4'b1011)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .core_idx(core_idx),
    .rdata(rdata), .rvalid(rvalid), .strap_filt_en(s_fen),
    .strap_mst_start(s_ms), .strap_mst_end(s_me),
    .strap_per_start(s_ps), .strap_per_end(s_pe));

  cohreg_block #(.NUM_CORES(6)) uut_cap (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .core_idx(core_idx),
    .rdata(rdata_cap), .rvalid(rvalid_cap), .strap_filt_en(s_fen),
    .strap_mst_start(s_ms), .strap_mst_end(s_me),
    .strap_per_start(s_ps), .strap_per_end(s_pe));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as read data returns
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R12 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [1:0] c,
                         input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    addr = a; core_idx = c; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [1:0] c);
    @(negedge clk);
    addr = a; wdata = d; core_idx = c; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit is_start);
    @(negedge clk);
    if (is_start) start = 1'b1; else soft_rst = 1'b1;
    @(negedge clk);
    start = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; start = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0; core_idx = '0;
    s_fen = 1'b1; s_ms = 32'h1234_5678; s_me = 32'h2000_0ABC;
    s_ps = 32'hABCD_EFFF; s_pe = 32'h000F_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_read(8'h00, 2'd0, 32'h0000_0000, "R1 ctrl after reset");
    do_read(8'h40, 2'd0, 32'h0000_0000, "R1 mst start after reset");
    do_read(8'h50, 2'd0, 32'h0000_0007, "R1 access after reset");
    do_read(8'h04, 2'd0, 32'h0000_0032, "R3/R4 cfg before start");
    do_read(8'h54, 2'd0, 32'h0000_0FFF, "R10 nsac");
    do_read(8'h08, 2'd0, 32'h0000_0000, "R10 unmapped");

    // R8 first start captures
    pulse(1'b1);
    do_read(8'h40, 2'd0, 32'h1230_0000, "R7 mst start");
    do_read(8'h44, 2'd0, 32'h2000_0000, "R7 mst end");
    do_read(8'h48, 2'd0, 32'hABC0_0000, "R7 per start");
    do_read(8'h4C, 2'd0, 32'h0000_0000, "R7 per end");
    do_read(8'h04, 2'd0, 32'h8000_0032, "R4 cfg after start");
    check("R11 capped core count", rdata_cap, 32'h8000_00F3);
    do_read(8'h00, 2'd0, 32'h0000_0002, "R2 ctrl filt flag");

    // R8 second start ignored
    s_fen = 1'b0; s_ms = 32'h0; s_me = 32'h5550_0000; s_ps = 32'h0; s_pe = 32'h7770_0000;
    pulse(1'b1);
    do_read(8'h40, 2'd0, 32'h1230_0000, "R8 no recapture mst");
    do_read(8'h4C, 2'd0, 32'h0000_0000, "R8 no recapture per end");
    do_read(8'h00, 2'd0, 32'h0000_0002, "R8 filt flag kept");

    // R2 control enable
    do_write(8'h00, 32'hFFFF_FFFF, 2'd0);
    do_read(8'h00, 2'd0, 32'h0000_0003, "R2 ctrl all ones");
    do_write(8'h00, 32'h0000_0000, 2'd0);
    do_read(8'h00, 2'd0, 32'h0000_0002, "R2 ctrl cleared");

    // R7 filter read only
    do_write(8'h40, 32'hFFFF_FFFF, 2'd0);
    do_read(8'h40, 2'd0, 32'h1230_0000, "R7 filter ignores write");
    // R10 writes ignored
    do_write(8'h54, 32'h0, 2'd0);
    do_write(8'h08, 32'hFFFF_FFFF, 2'd0);
    do_read(8'h54, 2'd0, 32'h0000_0FFF, "R10 nsac after write");
    do_read(8'h08, 2'd0, 32'h0000_0000, "R10 unmapped after write");

    // R5 lock core 1
    do_write(8'h50, 32'hFFFF_FFFD, 2'd0);
    do_read(8'h50, 2'd0, 32'h0000_0005, "R5 core1 locked");
    do_write(8'h00, 32'h1, 2'd1);
    do_read(8'h00, 2'd1, 32'h0000_0002, "R6 locked ctrl write dropped, R12 read ok");
    do_write(8'h50, 32'h0, 2'd1);
    do_read(8'h50, 2'd0, 32'h0000_0005, "R6 locked acc write dropped");
    do_write(8'h50, 32'hF, 2'd2);
    do_read(8'h50, 2'd0, 32'h0000_0005, "R5 one never unlocks");
    do_write(8'h00, 32'h1, 2'd2);
    do_read(8'h00, 2'd0, 32'h0000_0003, "R6 unlocked core writes");
    do_write(8'h00, 32'h0, 2'd3);
    do_read(8'h00, 2'd0, 32'h0000_0002, "R6 index above count not gated");
    do_write(8'h00, 32'h1, 2'd0);

    // R9 soft reset
    pulse(1'b0);
    do_read(8'h50, 2'd0, 32'h0000_0007, "R9 locks cleared");
    do_read(8'h00, 2'd0, 32'h0000_0002, "R9 enable cleared flag kept");
    pulse(1'b1);
    do_read(8'h44, 2'd0, 32'h2000_0000, "R9 filters kept no recapture");

    // self-lock of core 0
    do_write(8'h50, 32'hE, 2'd0);
    do_write(8'h00, 32'h1, 2'd0);
    do_read(8'h00, 2'd0, 32'h0000_0002, "R6 self-locked core dropped");
    do_read(8'h50, 2'd0, 32'h0000_0006, "R5 self lock");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R12 missing read data", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule